// File: doc/BRIEF.md
# Lockable Fully-Associative Translation Buffer

This block turns an effective page address into a physical page address by comparing the request against every stored entry at once. Each entry carries the page numbers, an address-space tag, a privilege-match field, a protection-group index, a page permission, cache attributes and its own page size. A lookup port returns hit, miss, a protection fault, the physical address and the write-through and cache-inhibit attributes within the same cycle. When translation is switched off, the address passes through unchanged and the attributes come from programmable defaults.

Software keeps the buffer filled. It writes entries through a command port, either at a given index or at the slot picked by a round-robin replacement pointer. It also uses this port to invalidate one entry or all entries, to set protection-group modes, and to reserve a number of low-index entries as locked. A miss only raises a flag, and software then loads the missing entry. There is no hardware table walk.

Top module: `xlat_buf`

## Requirements
- R1: `N_ENTRIES` (default 32) entries are compared in parallel. An entry hits when it is valid, its space tag equals `lk_asid_i`, its privilege field admits the request, and its page number equals `lk_ea_i[31:12]` on every bit at or above its page offset. If several entries hit, the lowest index wins.
- R2: The size code of an entry sets its page offset: 0 = 4 KB (12 bits), 1 = 16 KB (14), 2 = 512 KB (19), 3 = 8 MB (23). On a hit, `lk_pa_o` takes the entry's physical page bits above the offset and the request bits below it, and `lk_wt_o`/`lk_ci_o` take the entry's attributes.
- R3: A hit needs an exact match between the 4-bit space tag and the request's space ID. No tag value matches every space.
- R4: Privilege field bit 0 admits user requests (`lk_super_i`=0) and bit 1 admits supervisor requests. Code 3 admits both and code 0 admits neither.
- R5: On a hit, `lk_fault_o` is decided by the mode of the entry's protection group: 1 = always fault, 2 = never fault, 3 = fault on write only. Only in mode 0 does the page permission apply: pp 0 faults on any access, pp 1 faults on writes, and pp 2 or 3 never faults.
- R6: `lk_miss_o` = `lk_req_i` and translation on and no hit. `lk_hit_o` needs `lk_req_i` as well. Hit and miss never rise together, and a fault only comes with a hit.
- R7: With `xlat_en_i`=0, `lk_pa_o` equals `lk_ea_i`, `lk_wt_o`/`lk_ci_o` equal the default registers, and hit, miss and fault stay low.
- R8: Commands on `cmd_i` (0 none, 1 replace-load, 2 indexed load at `cmd_idx_i`, 3 invalidate-one, 4 invalidate-all, 5 sync, 6 set group `cmd_grp_i` to mode `cmd_perm_i`, 7 config) take effect at the next rising clock edge. Config loads the default write-through and cache-inhibit values from `cmd_wt_i`/`cmd_ci_i` and sets the lock count from `cmd_idx_i`.
- R9: A replace-load writes the victim slot. The victim is the pointer, or the lock count if the pointer is below it. The pointer then moves to victim+1, and wraps from the last entry back to the lock count.
- R10: The lock count saturates at `LOCK_MAX` (4). Entries below the lock count are never written by a replace-load.
- R11: Invalidate-one clears every valid entry whose space tag equals `cmd_asid_i` and whose page covers `cmd_vpn_i` under its own size, whatever its privilege field. Other entries keep their contents.
- R12: Invalidate-all clears every entry, locked ones included. The lock count and the replacement pointer do not change.
- R13: The sync command changes no state.
- R14: After reset all entries are invalid, all groups are in mode 0, the defaults are 0, the lock count is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| xlat_en_i | input | 1 | Translation enable |
| lk_ea_i | input | 32 | Effective address |
| lk_asid_i | input | 4 | Current address-space ID |
| lk_super_i | input | 1 | Supervisor request |
| lk_write_i | input | 1 | Write access |
| lk_hit_o | output | 1 | Translation hit |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Protection violation on hit |
| lk_pa_o | output | 32 | Physical address |
| lk_wt_o | output | 1 | Write-through attribute |
| lk_ci_o | output | 1 | Cache-inhibit attribute |
| cmd_i | input | 3 | Command code |
| cmd_idx_i | input | 5 | Entry index or lock count |
| cmd_vpn_i | input | 20 | Effective page number for load or invalidate |
| cmd_ppn_i | input | 20 | Physical page number for load |
| cmd_asid_i | input | 4 | Space tag for load or invalidate |
| cmd_size_i | input | 2 | Page size code |
| cmd_priv_i | input | 2 | Privilege-match field |
| cmd_grp_i | input | 4 | Protection group index |
| cmd_perm_i | input | 2 | Page permission, or group mode |
| cmd_wt_i | input | 1 | Write-through attribute or default |
| cmd_ci_i | input | 1 | Cache-inhibit attribute or default |

## Verification
Lookups are combinational over the stored state, so a corrupted entry, group mode or default register shows up on hit, miss, fault or address in the first lookup after the command that caused it. A replacement pointer that stepped into a locked slot, or that wrapped to the wrong place, does not show up at once. It shows as a missing translation only when a later lookup reaches the overwritten page. For that reason the bench loads more entries than the buffer holds and then sweeps every page it has loaded. A mask error in the page size shows as a hit or miss that flips at the wrong address bit, and single-bit address sweeps find it.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int EA_W   = 32;
  localparam int PG_LSB = 12;
  localparam int VPN_W  = EA_W - PG_LSB;
  localparam int ASID_W = 4;
  localparam int GRP_W  = 4;
  localparam int NGRP   = 1 << GRP_W;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_LOAD, CMD_LOAD_AT, CMD_INV_ONE,
    CMD_INV_ALL, CMD_SYNC, CMD_SET_GRP, CMD_SET_CFG
  } cmd_e;

  typedef enum logic [1:0] {GRP_PAGE, GRP_DENY, GRP_FULL, GRP_RO} grp_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [1:0]        size;
    logic [1:0]        priv;   // [0] user, [1] supervisor
    logic [GRP_W-1:0]  grp;
    logic [1:0]        pp;
    logic              wt;
    logic              ci;
  } entry_t;

  // page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] size_mask(logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    unique case (sz)
      2'd0: m = m;
      2'd1: m = m << 2;
      2'd2: m = m << 7;
      default: m = m << 11;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xlat_cam_cell.sv
module xlat_cam_cell
  import xlat_pkg::*;
(
  input  entry_t            ent_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_super_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  output logic              lk_hit_o,
  output logic              inv_hit_o
);
  logic [VPN_W-1:0] mask;
  logic             priv_ok;

  assign mask      = size_mask(ent_i.size);
  assign priv_ok   = lk_super_i ? ent_i.priv[1] : ent_i.priv[0];
  assign lk_hit_o  = ent_i.valid && (ent_i.asid == lk_asid_i) && priv_ok &&
                     (((ent_i.vpn ^ lk_vpn_i) & mask) == '0);
  assign inv_hit_o = ent_i.valid && (ent_i.asid == inv_asid_i) &&
                     (((ent_i.vpn ^ inv_vpn_i) & mask) == '0);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENTRIES = 32,
  parameter int IDX_W     = 5,
  parameter int LCNT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [LCNT_W-1:0] lock_cnt_i,
  output logic [IDX_W-1:0]  victim_o
);
  logic [IDX_W-1:0] ptr_q;

  assign victim_o = (int'(ptr_q) < int'(lock_cnt_i)) ? IDX_W'(lock_cnt_i) : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i)
      ptr_q <= (int'(victim_o) == N_ENTRIES - 1) ? IDX_W'(lock_cnt_i)
                                                 : victim_o + IDX_W'(1);
  end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  grp_e       grp_mode_i,
  input  logic [1:0] pp_i,
  input  logic       write_i,
  output logic       fault_o
);
  always_comb begin
    unique case (grp_mode_i)
      GRP_DENY: fault_o = 1'b1;
      GRP_FULL: fault_o = 1'b0;
      GRP_RO:   fault_o = write_i;
      default:  fault_o = (pp_i == 2'd0) || (write_i && pp_i == 2'd1);
    endcase
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int LOCK_MAX  = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int LCNT_W   = $clog2(LOCK_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic              xlat_en_i,
  input  logic [EA_W-1:0]   lk_ea_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_super_i,
  input  logic              lk_write_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [EA_W-1:0]   lk_pa_o,
  output logic              lk_wt_o,
  output logic              lk_ci_o,
  input  logic [2:0]        cmd_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [VPN_W-1:0]  cmd_vpn_i,
  input  logic [VPN_W-1:0]  cmd_ppn_i,
  input  logic [ASID_W-1:0] cmd_asid_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [1:0]        cmd_priv_i,
  input  logic [GRP_W-1:0]  cmd_grp_i,
  input  logic [1:0]        cmd_perm_i,
  input  logic              cmd_wt_i,
  input  logic              cmd_ci_i
);
  entry_t              ent_q [N_ENTRIES];
  grp_e                grp_q [NGRP];
  logic                dflt_wt_q, dflt_ci_q;
  logic [LCNT_W-1:0]   lock_cnt_q;
  logic [N_ENTRIES-1:0] lk_hit, inv_hit;
  logic [IDX_W-1:0]    victim, sel_idx;
  logic                any_hit, pg_fault;
  entry_t              sel, new_ent;
  logic [VPN_W-1:0]    sel_mask;
  cmd_e                cmd;

  assign cmd = cmd_e'(cmd_i);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cell
    xlat_cam_cell u_cell (
      .ent_i      (ent_q[g]),
      .lk_vpn_i   (lk_ea_i[EA_W-1:PG_LSB]),
      .lk_asid_i  (lk_asid_i),
      .lk_super_i (lk_super_i),
      .inv_vpn_i  (cmd_vpn_i),
      .inv_asid_i (cmd_asid_i),
      .lk_hit_o   (lk_hit[g]),
      .inv_hit_o  (inv_hit[g])
    );
  end

  // lowest index wins
  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit[i]) begin
        any_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign sel      = ent_q[sel_idx];
  assign sel_mask = size_mask(sel.size);

  xlat_perm u_perm (
    .grp_mode_i (grp_q[sel.grp]),
    .pp_i       (sel.pp),
    .write_i    (lk_write_i),
    .fault_o    (pg_fault)
  );

  xlat_victim #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .LCNT_W(LCNT_W)) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (cmd == CMD_LOAD),
    .lock_cnt_i (lock_cnt_q),
    .victim_o   (victim)
  );

  assign lk_hit_o   = lk_req_i && xlat_en_i && any_hit;
  assign lk_miss_o  = lk_req_i && xlat_en_i && !any_hit;
  assign lk_fault_o = lk_hit_o && pg_fault;
  assign lk_pa_o    = xlat_en_i ? {(sel.ppn & sel_mask) | (lk_ea_i[EA_W-1:PG_LSB] & ~sel_mask),
                                   lk_ea_i[PG_LSB-1:0]}
                                : lk_ea_i;
  assign lk_wt_o    = xlat_en_i ? sel.wt : dflt_wt_q;
  assign lk_ci_o    = xlat_en_i ? sel.ci : dflt_ci_q;

  assign new_ent = '{valid: 1'b1, vpn: cmd_vpn_i, ppn: cmd_ppn_i, asid: cmd_asid_i,
                     size: cmd_size_i, priv: cmd_priv_i, grp: cmd_grp_i,
                     pp: cmd_perm_i, wt: cmd_wt_i, ci: cmd_ci_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
      for (int i = 0; i < NGRP; i++) grp_q[i] <= GRP_PAGE;
      dflt_wt_q  <= 1'b0;
      dflt_ci_q  <= 1'b0;
      lock_cnt_q <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD:    ent_q[victim]    <= new_ent;
        CMD_LOAD_AT: ent_q[cmd_idx_i] <= new_ent;
        CMD_INV_ONE: for (int i = 0; i < N_ENTRIES; i++)
                       if (inv_hit[i]) ent_q[i].valid <= 1'b0;
        CMD_INV_ALL: for (int i = 0; i < N_ENTRIES; i++) ent_q[i].valid <= 1'b0;
        CMD_SET_GRP: grp_q[cmd_grp_i] <= grp_e'(cmd_perm_i);
        CMD_SET_CFG: begin
          dflt_wt_q  <= cmd_wt_i;
          dflt_ci_q  <= cmd_ci_i;
          lock_cnt_q <= (int'(cmd_idx_i) > LOCK_MAX) ? LCNT_W'(LOCK_MAX) : LCNT_W'(cmd_idx_i);
        end
        default: ;
      endcase
    end
  end
endmodule

module xlat_buf_chk #(
  parameter int IDX_W    = 5,
  parameter int LCNT_W   = 3,
  parameter int LOCK_MAX = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_req_i,
  input logic              xlat_en_i,
  input logic [31:0]       lk_ea_i,
  input logic [31:0]       lk_pa_o,
  input logic              lk_hit_o,
  input logic              lk_miss_o,
  input logic              lk_fault_o,
  input logic [2:0]        cmd_i,
  input logic [LCNT_W-1:0] lock_cnt,
  input logic [IDX_W-1:0]  victim
);
  // R6
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));
  // R6
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);
  // R6
  miss_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> (lk_req_i && xlat_en_i));
  // R7
  bypass_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (lk_pa_o == lk_ea_i && !lk_hit_o && !lk_miss_o));
  // R12
  inv_all_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4) |=> !lk_hit_o);
  // R10
  lock_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(lock_cnt) <= LOCK_MAX);
  // R10
  victim_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(victim) >= int'(lock_cnt));
endmodule

bind xlat_buf xlat_buf_chk #(.IDX_W(IDX_W), .LCNT_W(LCNT_W), .LOCK_MAX(LOCK_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_req_i   (lk_req_i),
  .xlat_en_i  (xlat_en_i),
  .lk_ea_i    (lk_ea_i),
  .lk_pa_o    (lk_pa_o),
  .lk_hit_o   (lk_hit_o),
  .lk_miss_o  (lk_miss_o),
  .lk_fault_o (lk_fault_o),
  .cmd_i      (cmd_i),
  .lock_cnt   (lock_cnt_q),
  .victim     (victim)
);

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;
  localparam int N = 32;
  localparam int LMAX = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, xlat_en = 0, lk_super = 0, lk_write = 0;
  logic [31:0] lk_ea = '0;
  logic [3:0]  lk_asid = '0;
  logic lk_hit, lk_miss, lk_fault, lk_wt, lk_ci;
  logic [31:0] lk_pa;
  logic [2:0]  cmd_c = '0;
  logic [4:0]  c_idx = '0;
  logic [19:0] c_vpn = '0, c_ppn = '0;
  logic [3:0]  c_asid = '0, c_grp = '0;
  logic [1:0]  c_size = '0, c_priv = '0, c_perm = '0;
  logic        c_wt = 0, c_ci = 0;

  int vecs = 0, fails = 0;
  bit done = 0;

  // reference state
  logic        m_valid [N];
  logic [19:0] m_vpn [N], m_ppn [N];
  logic [3:0]  m_asid [N], m_grp [N];
  logic [1:0]  m_size [N], m_priv [N], m_pp [N];
  logic        m_wt [N], m_ci [N];
  logic [1:0]  m_gmode [16];
  logic        m_dwt = 0, m_dci = 0;
  int          m_lock = 0, m_ptr = 0;

  always #5 clk = ~clk;

  xlat_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .xlat_en_i(xlat_en),
    .lk_ea_i(lk_ea), .lk_asid_i(lk_asid), .lk_super_i(lk_super), .lk_write_i(lk_write),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault), .lk_pa_o(lk_pa),
    .lk_wt_o(lk_wt), .lk_ci_o(lk_ci), .cmd_i(cmd_c), .cmd_idx_i(c_idx),
    .cmd_vpn_i(c_vpn), .cmd_ppn_i(c_ppn), .cmd_asid_i(c_asid), .cmd_size_i(c_size),
    .cmd_priv_i(c_priv), .cmd_grp_i(c_grp), .cmd_perm_i(c_perm), .cmd_wt_i(c_wt),
    .cmd_ci_i(c_ci)
  );

  function automatic logic [19:0] pmask(logic [1:0] s);
    case (s)
      2'd0: return 20'hFFFFF;
      2'd1: return 20'hFFFFC;
      2'd2: return 20'hFFF80;
      default: return 20'hFF800;
    endcase
  endfunction

  task automatic cmd(input logic [2:0] c, input logic [4:0] idx, input logic [19:0] vpn, ppn,
                     input logic [3:0] as, input logic [1:0] sz, pr, input logic [3:0] g,
                     input logic [1:0] pp, input logic wt, ci);
    int v;
    @(negedge clk);
    cmd_c = c; c_idx = idx; c_vpn = vpn; c_ppn = ppn; c_asid = as; c_size = sz;
    c_priv = pr; c_grp = g; c_perm = pp; c_wt = wt; c_ci = ci;
    @(negedge clk);
    cmd_c = 3'd0;
    v = -1;
    case (c)
      3'd1: begin
        v = (m_ptr < m_lock) ? m_lock : m_ptr;
        m_ptr = (v == N - 1) ? m_lock : v + 1;
      end
      3'd2: v = int'(idx);
      3'd3: for (int i = 0; i < N; i++)
              if (m_valid[i] && m_asid[i] == as && ((m_vpn[i] ^ vpn) & pmask(m_size[i])) == 0)
                m_valid[i] = 0;
      3'd4: for (int i = 0; i < N; i++) m_valid[i] = 0;
      3'd6: m_gmode[g] = pp;
      3'd7: begin m_dwt = wt; m_dci = ci; m_lock = (int'(idx) > LMAX) ? LMAX : int'(idx); end
      default: ;
    endcase
    if (v >= 0) begin
      m_valid[v] = 1; m_vpn[v] = vpn; m_ppn[v] = ppn; m_asid[v] = as; m_size[v] = sz;
      m_priv[v] = pr; m_grp[v] = g; m_pp[v] = pp; m_wt[v] = wt; m_ci[v] = ci;
    end
  endtask

  task automatic ld_at(input int idx, input logic [19:0] vpn, input logic [1:0] sz,
                       input logic [1:0] pr, input logic [3:0] as);
    cmd(3'd2, 5'(idx), vpn, vpn ^ 20'h5A5A5, as, sz, pr, 4'd0, 2'd2, vpn[0], vpn[1]);
  endtask

  task automatic ld(input logic [19:0] vpn);
    cmd(3'd1, 5'd0, vpn, vpn ^ 20'h33CC3, 4'd0, 2'd0, 2'd3, 4'd0, 2'd2, vpn[1], vpn[0]);
  endtask

  task automatic look(input logic [31:0] ea, input logic [3:0] as, input logic sup, wr,
                      input logic en, rq, input string tag);
    logic eh, em, ef, ewt, eci;
    logic [31:0] epa;
    logic [19:0] m;
    logic [1:0] gm;
    int hi;
    @(negedge clk);
    lk_ea = ea; lk_asid = as; lk_super = sup; lk_write = wr; xlat_en = en; lk_req = rq;
    #2;
    hi = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_valid[i] && m_asid[i] == as && (sup ? m_priv[i][1] : m_priv[i][0]) &&
          ((m_vpn[i] ^ ea[31:12]) & pmask(m_size[i])) == 0) hi = i;
    eh = rq && en && hi >= 0;
    em = rq && en && hi < 0;
    ef = 0; epa = ea; ewt = m_dwt; eci = m_dci;
    if (en && hi >= 0) begin
      m = pmask(m_size[hi]);
      epa = {(m_ppn[hi] & m) | (ea[31:12] & ~m), ea[11:0]};
      ewt = m_wt[hi]; eci = m_ci[hi];
      gm = m_gmode[m_grp[hi]];
      case (gm)
        2'd1: ef = 1;
        2'd2: ef = 0;
        2'd3: ef = wr;
        default: ef = (m_pp[hi] == 0) || (wr && m_pp[hi] == 1);
      endcase
      ef = ef && eh;
    end
    vecs++;
    if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef ||
        ((eh || !en) && (lk_pa !== epa || lk_wt !== ewt || lk_ci !== eci))) begin
      fails++;
      $display("FAIL %s ea=%h got h%b m%b f%b pa=%h wt%b ci%b exp h%b m%b f%b pa=%h wt%b ci%b",
               tag, ea, lk_hit, lk_miss, lk_fault, lk_pa, lk_wt, lk_ci, eh, em, ef, epa, ewt, eci);
    end
  endtask

  task automatic sweep(input logic [19:0] base, input int cnt, input string tag);
    for (int j = 0; j < cnt; j++) look({base + 20'(j), 12'h3A4}, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    for (int i = 0; i < 16; i++) m_gmode[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R14: empty after reset, defaults zero
    for (int k = 0; k < 4; k++) look(32'h1234_5000 + 32'(k * 4096), 4'(k), k[0], 1'b0, 1'b1, 1'b1, "R14");
    look(32'hDEAD_BEEF, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R14");

    // R2 R1 R8: each page size, flip every address bit 0..23
    for (int sz = 0; sz < 4; sz++) begin
      cmd(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      ld_at(sz * 3 + 1, 20'hABCDE, 2'(sz), 2'd3, 4'd0);
      look({20'hABCDE, 12'h000}, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
      for (int k = 0; k < 24; k++)
        look({20'hABCDE, 12'h000} ^ (32'd1 << k), 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
    end

    // R1: lowest index wins on overlap
    ld_at(9, 20'hABCDE, 2'd0, 2'd3, 4'd0);
    look({20'hABCDE, 12'h010}, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R1");

    // R3: space tag sweep
    cmd(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ld_at(7, 20'h00042, 2'd1, 2'd3, 4'd5);
    for (int a = 0; a < 16; a++) look({20'h00042, 12'h800}, 4'(a), 1'b0, 1'b0, 1'b1, 1'b1, "R3");

    // R4: privilege field against user/supervisor
    for (int pr = 0; pr < 4; pr++) begin
      ld_at(0, 20'h00777, 2'd0, 2'(pr), 4'd0);
      for (int s = 0; s < 2; s++) look({20'h00777, 12'h004}, 4'd0, s[0], 1'b0, 1'b1, 1'b1, "R4");
    end

    // R5: group mode x page permission x access type
    for (int g = 0; g < 4; g++) begin
      cmd(3'd6, 0, 0, 0, 0, 0, 0, 4'd3, 2'(g), 0, 0);
      for (int pp = 0; pp < 4; pp++) begin
        cmd(3'd2, 5'd2, 20'h01000, 20'h0F0F0, 4'd1, 2'd0, 2'd3, 4'd3, 2'(pp), pp[0], pp[1]);
        for (int w = 0; w < 2; w++) look({20'h01000, 12'h0FC}, 4'd1, 1'b1, w[0], 1'b1, 1'b1, "R5");
      end
    end

    // R6: no request, nothing asserted
    look({20'h01000, 12'h0FC}, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    look(32'h7777_0000, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R6");

    // R7: bypass with each default pair
    for (int d = 0; d < 4; d++) begin
      cmd(3'd7, 0, 0, 0, 0, 0, 0, 0, 0, d[0], d[1]);
      look({20'h01000, 12'h0FC}, 4'd1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      look(32'hFFFF_FFFF - 32'(d), 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    end

    // R9 R10: lock two, fill past capacity
    cmd(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cmd(3'd7, 5'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ld_at(0, 20'h00100, 2'd0, 2'd3, 4'd0);
    ld_at(1, 20'h00101, 2'd0, 2'd3, 4'd0);
    for (int j = 0; j < 40; j++) ld(20'h00200 + 20'(j));
    sweep(20'h00100, 2, "R10");
    sweep(20'h00200, 40, "R9");

    // R10: lock count saturates, newly locked slots survive
    cmd(3'd7, 5'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ld_at(2, 20'h00300, 2'd0, 2'd3, 4'd0);
    ld_at(3, 20'h00301, 2'd0, 2'd3, 4'd0);
    for (int j = 0; j < 31; j++) ld(20'h00400 + 20'(j));
    sweep(20'h00300, 2, "R10");
    sweep(20'h00100, 2, "R10");
    sweep(20'h00400, 31, "R9");

    // R13: sync leaves state alone
    cmd(3'd5, 5'd0, 20'h00400, 0, 0, 0, 0, 0, 0, 1, 1);
    sweep(20'h00400, 31, "R13");
    look(32'h0000_0000, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R13");

    // R11: wrong tag has no effect, right tag clears only that page
    cmd(3'd3, 0, 20'h00410, 0, 4'd9, 0, 0, 0, 0, 0, 0);
    sweep(20'h00410, 1, "R11");
    cmd(3'd3, 0, 20'h00410, 0, 4'd0, 0, 0, 0, 0, 0, 0);
    sweep(20'h0040E, 5, "R11");
    ld_at(5, 20'h08000, 2'd3, 2'd1, 4'd0);
    cmd(3'd3, 0, 20'h08123, 0, 4'd0, 0, 0, 0, 0, 0, 0);
    look({20'h08000, 12'h000}, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
    sweep(20'h00100, 2, "R11");

    // R12: clear all incl. locked; lock count and pointer kept
    cmd(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    sweep(20'h00100, 2, "R12");
    sweep(20'h00300, 2, "R12");
    sweep(20'h00400, 31, "R12");
    ld_at(0, 20'h00500, 2'd0, 2'd3, 4'd0);
    for (int j = 0; j < N - LMAX; j++) ld(20'h00600 + 20'(j));
    sweep(20'h00500, 1, "R12");
    sweep(20'h00600, N - LMAX, "R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule